// File: doc/BRIEF.md
# Cartridge Memory Bank Mapper

This block sits between a console's CPU and video bus and a game cartridge's memories. CPU writes to the top half of the CPU address space load a set of bank registers. The block then turns every video-bus address into a 1 KB bank number, and every upper CPU address into an 8 KB program bank number. Each video lookup also carries a flag. The flag says whether the access goes to character ROM or to the console's internal video RAM.

Twelve 1 KB video slots cover the address space: eight for pattern data at video 0x0000-0x1FFF and four for nametables at 0x2000-0x3FFF. A pattern slot can be pointed at internal video RAM instead of ROM. The choice is made when the slot is written, and it depends on the value written and on a per-half disable flag. A build parameter selects one of four variants. In variants 1 to 3 the nametable registers ignore CPU writes. In variants 2 and 3 a program-bank write instead sets a mirroring arrangement on the nametable slots. A separate exact-address write latches a byte for an external sound unit and pulses a strobe.

Top module: `cart_bank_mapper`

## Requirements
- R1: After reset, every video slot maps to ROM bank 0, and program windows 0x8000, 0xA000 and 0xC000 give bank 0. The sound byte and strobe are 0, and `mirror_mode` is 0.
- R2: A write (`cpu_wr` high at a rising edge) selects a register by CPU address bits [15:11]. Windows 0x8000, 0x8800 ... 0xB800 load pattern slots 0..7 in order, and a write below 0x8000 changes nothing. Pattern slot k serves video addresses whose bits [12:10] equal k while bit 13 is 0.
- R3: A value below 0xE0 written to a pattern slot maps it to ROM bank = value (`ppu_vram`=0). A value of 0xE0 or above maps it to video RAM bank = value[4:0] (`ppu_vram`=1), unless the disable flag of that slot's half is set, in which case it maps to ROM bank = value.
- R4: A write in window 0xE800 sets the low-half disable flag (slots 0-3) from data bit 6 and the high-half flag (slots 4-7) from data bit 7. The flag value used is the one in force when the slot is written, so changing a flag later leaves loaded slots unchanged.
- R5: In variant 0, windows 0xC000, 0xC800, 0xD000 and 0xD800 load nametable slots 0..3. Nametable slot k serves video addresses with bit 13 set and bits [11:10] equal to k. A value up to 0xDF maps to ROM bank = value, and a larger value maps to video RAM page value[0].
- R6: Windows 0xE000, 0xE800 and 0xF000 set the program banks for CPU 0x8000, 0xA000 and 0xC000 from data[5:0]. CPU 0xE000-0xFFFF always gives bank `PRG_BANKS`-1.
- R7: A write exactly at 0xF800 latches the whole data byte into `snd_addr` and makes `snd_strobe` high for the following cycle only. Any other address in window 0xF800 has no effect.
- R8: In variants 1, 2 and 3, writes to the nametable windows leave the nametable slots unchanged.
- R9: In variant 2, a 0xE000 write sets `mirror_mode` to 1 (vertical: nametable slots map to video RAM pages 0,1,0,1) when data bit 6 is set. When bit 6 is clear it sets `mirror_mode` to 3 (single lower: all four slots map to page 0).
- R10: In variant 3, a 0xE000 write sets `mirror_mode` to 2 (horizontal: pages 0,0,1,1) when data bit 7 is set, and to 1 (vertical) when it is clear.
- R11: In variants 0 and 1, `mirror_mode` stays 0 (mapping taken from the nametable slots).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_wr | input | 1 | Qualified CPU write strobe |
| cpu_addr | input | 16 | CPU address, used both for write decode and program-bank lookup |
| cpu_data | input | 8 | CPU write data |
| ppu_addr | input | 14 | Video bus address |
| ppu_bank | output | 8 | Selected 1 KB bank for `ppu_addr` |
| ppu_vram | output | 1 | 1 = access goes to internal video RAM, 0 = character ROM |
| prg_bank | output | 6 | Selected 8 KB program bank for `cpu_addr` (upper half) |
| snd_addr | output | 8 | Latched sound unit address byte |
| snd_strobe | output | 1 | One-cycle pulse after a sound address write |
| mirror_mode | output | 2 | 0 slots, 1 vertical, 2 horizontal, 3 single lower |

## Verification
The bench pushes the values on either side of both thresholds, 0xDF against 0xE0, into pattern and nametable slots. A comparator off by one would send one of those values to the wrong memory. It toggles the disable flags after slots are loaded; a design that applies the flag at lookup time instead of at write time would remap slots that were already loaded. It writes 0xF801 and other nearby addresses to catch a sound decode that only looks at the window, and writes nametable windows in every variant to catch a variant that fails to ignore them. Each mirroring bit is driven both ways to expose swapped page patterns.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 16;
  localparam int BANK_W  = 8;
  localparam int PRG_W   = 6;
  localparam int N_PAT   = 8;
  localparam int N_NT    = 4;
  localparam int N_PRG   = 3;
  localparam int WIN_W   = 4;
  localparam logic [DATA_W-1:0] PAT_RAM_MIN = 8'hE0;
  localparam logic [DATA_W-1:0] NT_ROM_MAX  = 8'hDF;
  localparam logic [ADDR_W-1:0] SND_ADDR    = 16'hF800;

  typedef struct packed {
    logic              vram;
    logic [BANK_W-1:0] bank;
  } slot_t;

  typedef enum logic [1:0] {
    MIR_SLOTS  = 2'd0,
    MIR_VERT   = 2'd1,
    MIR_HORZ   = 2'd2,
    MIR_ONE_LO = 2'd3
  } mir_e;

  function automatic slot_t chr_slot(input logic [DATA_W-1:0] d, input logic dis);
    slot_t s;
    if (d < PAT_RAM_MIN || dis) begin
      s.vram = 1'b0;
      s.bank = d;
    end else begin
      s.vram = 1'b1;
      s.bank = {3'b000, d[4:0]};
    end
    return s;
  endfunction

  function automatic slot_t nt_slot(input logic [DATA_W-1:0] d);
    slot_t s;
    if (d <= NT_ROM_MAX) begin
      s.vram = 1'b0;
      s.bank = d;
    end else begin
      s.vram = 1'b1;
      s.bank = {7'b0, d[0]};
    end
    return s;
  endfunction

  function automatic slot_t mir_slot(input mir_e m, input logic [1:0] idx);
    slot_t s;
    s.vram = 1'b1;
    case (m)
      MIR_VERT: s.bank = {7'b0, idx[0]};
      MIR_HORZ: s.bank = {7'b0, idx[1]};
      default:  s.bank = '0;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/cbm_decode.sv
module cbm_decode
  import cbm_pkg::*;
(
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output logic [N_PAT-1:0]  pat_we,
  output logic [N_NT-1:0]   nt_we,
  output logic [N_PRG-1:0]  prg_we,
  output logic              snd_we
);
  localparam int NT_BASE  = N_PAT;
  localparam int PRG_BASE = N_PAT + N_NT;

  logic             hit;
  logic [WIN_W-1:0] win;

  assign hit = wr & addr[ADDR_W-1];
  assign win = addr[ADDR_W-2 -: WIN_W];

  for (genvar g = 0; g < N_PAT; g++) begin : g_pat
    assign pat_we[g] = hit && (win == WIN_W'(g));
  end
  for (genvar g = 0; g < N_NT; g++) begin : g_nt
    assign nt_we[g] = hit && (win == WIN_W'(NT_BASE + g));
  end
  for (genvar g = 0; g < N_PRG; g++) begin : g_prg
    assign prg_we[g] = hit && (win == WIN_W'(PRG_BASE + g));
  end

  assign snd_we = wr && (addr == SND_ADDR);
endmodule

// File: rtl/cbm_regs.sv
module cbm_regs
  import cbm_pkg::*;
#(
  parameter int VARIANT = 0
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [N_PAT-1:0]               pat_we,
  input  logic [N_NT-1:0]                nt_we,
  input  logic [N_PRG-1:0]               prg_we,
  input  logic                           snd_we,
  input  logic [DATA_W-1:0]              data,
  output slot_t [N_PAT-1:0]              pat_q,
  output slot_t [N_NT-1:0]               nt_q,
  output logic [N_PRG-1:0][PRG_W-1:0]    prg_q,
  output mir_e                           mir_q,
  output logic [DATA_W-1:0]              snd_q,
  output logic                           stb_q
);
  localparam int HALF = N_PAT / 2;

  slot_t [N_PAT-1:0]            pat_d;
  slot_t [N_NT-1:0]             nt_d;
  logic [N_PRG-1:0][PRG_W-1:0]  prg_d;
  mir_e                         mir_d;
  logic                         dis_lo_q, dis_lo_d;
  logic                         dis_hi_q, dis_hi_d;
  logic [DATA_W-1:0]            snd_d;
  logic                         state_en;

  assign state_en = (|pat_we) | (|nt_we) | (|prg_we) | snd_we;

  always_comb begin
    pat_d    = pat_q;
    nt_d     = nt_q;
    prg_d    = prg_q;
    mir_d    = mir_q;
    dis_lo_d = dis_lo_q;
    dis_hi_d = dis_hi_q;
    snd_d    = snd_q;

    for (int i = 0; i < N_PAT; i++) begin
      if (pat_we[i]) pat_d[i] = chr_slot(data, (i < HALF) ? dis_lo_q : dis_hi_q);
    end

    if (VARIANT == 0) begin
      for (int i = 0; i < N_NT; i++) begin
        if (nt_we[i]) nt_d[i] = nt_slot(data);
      end
    end

    for (int i = 0; i < N_PRG; i++) begin
      if (prg_we[i]) prg_d[i] = data[PRG_W-1:0];
    end

    if (prg_we[1]) begin
      dis_lo_d = data[6];
      dis_hi_d = data[7];
    end

    if (prg_we[0] && VARIANT >= 2) begin
      if (VARIANT == 2) mir_d = data[6] ? MIR_VERT : MIR_ONE_LO;
      else              mir_d = data[7] ? MIR_HORZ : MIR_VERT;
      for (int i = 0; i < N_NT; i++) nt_d[i] = mir_slot(mir_d, 2'(i));
    end

    if (snd_we) snd_d = data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pat_q    <= '0;
      nt_q     <= '0;
      prg_q    <= '0;
      mir_q    <= MIR_SLOTS;
      dis_lo_q <= 1'b0;
      dis_hi_q <= 1'b0;
      snd_q    <= '0;
    end else if (state_en) begin
      pat_q    <= pat_d;
      nt_q     <= nt_d;
      prg_q    <= prg_d;
      mir_q    <= mir_d;
      dis_lo_q <= dis_lo_d;
      dis_hi_q <= dis_hi_d;
      snd_q    <= snd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb_q <= 1'b0;
    else        stb_q <= snd_we;
  end
endmodule

// File: rtl/cbm_ppu_xlat.sv
module cbm_ppu_xlat
  import cbm_pkg::*;
(
  input  logic [13:0]          ppu_addr,
  input  slot_t [N_PAT-1:0]    pat_q,
  input  slot_t [N_NT-1:0]     nt_q,
  output slot_t                sel
);
  always_comb begin
    if (ppu_addr[13]) sel = nt_q[ppu_addr[11:10]];
    else              sel = pat_q[ppu_addr[12:10]];
  end
endmodule

// File: rtl/cbm_prg_xlat.sv
module cbm_prg_xlat
  import cbm_pkg::*;
#(
  parameter int PRG_BANKS = 64
) (
  input  logic [ADDR_W-1:0]            addr,
  input  logic [N_PRG-1:0][PRG_W-1:0]  prg_q,
  output logic [PRG_W-1:0]             bank
);
  localparam logic [PRG_W-1:0] LAST_BANK = PRG_W'(PRG_BANKS - 1);

  always_comb begin
    case (addr[14:13])
      2'd0:    bank = prg_q[0];
      2'd1:    bank = prg_q[1];
      2'd2:    bank = prg_q[2];
      default: bank = LAST_BANK;
    endcase
  end
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
  import cbm_pkg::*;
#(
  parameter int VARIANT   = 0,
  parameter int PRG_BANKS = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_wr,
  input  logic [15:0] cpu_addr,
  input  logic [7:0]  cpu_data,
  input  logic [13:0] ppu_addr,
  output logic [7:0]  ppu_bank,
  output logic        ppu_vram,
  output logic [5:0]  prg_bank,
  output logic [7:0]  snd_addr,
  output logic        snd_strobe,
  output logic [1:0]  mirror_mode
);
  logic [1:0]                   rst_pipe;
  logic                         rst_sync_n;
  logic [N_PAT-1:0]             pat_we;
  logic [N_NT-1:0]              nt_we;
  logic [N_PRG-1:0]             prg_we;
  logic                         snd_we;
  slot_t [N_PAT-1:0]            pat_q;
  slot_t [N_NT-1:0]             nt_q;
  logic [N_PRG-1:0][PRG_W-1:0]  prg_q;
  mir_e                         mir_q;
  slot_t                        ppu_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  cbm_decode u_decode (
    .wr     (cpu_wr),
    .addr   (cpu_addr),
    .pat_we (pat_we),
    .nt_we  (nt_we),
    .prg_we (prg_we),
    .snd_we (snd_we)
  );

  cbm_regs #(.VARIANT(VARIANT)) u_regs (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .pat_we (pat_we),
    .nt_we  (nt_we),
    .prg_we (prg_we),
    .snd_we (snd_we),
    .data   (cpu_data),
    .pat_q  (pat_q),
    .nt_q   (nt_q),
    .prg_q  (prg_q),
    .mir_q  (mir_q),
    .snd_q  (snd_addr),
    .stb_q  (snd_strobe)
  );

  cbm_ppu_xlat u_ppu (
    .ppu_addr (ppu_addr),
    .pat_q    (pat_q),
    .nt_q     (nt_q),
    .sel      (ppu_sel)
  );

  cbm_prg_xlat #(.PRG_BANKS(PRG_BANKS)) u_prg (
    .addr  (cpu_addr),
    .prg_q (prg_q),
    .bank  (prg_bank)
  );

  assign ppu_bank    = ppu_sel.bank;
  assign ppu_vram    = ppu_sel.vram;
  assign mirror_mode = mir_q;
endmodule

// File: rtl/cbm_checker.sv
module cbm_checker #(
  parameter int VARIANT   = 0,
  parameter int PRG_BANKS = 64
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_wr,
  input logic [15:0] cpu_addr,
  input logic [7:0]  cpu_data,
  input logic [13:0] ppu_addr,
  input logic [7:0]  ppu_bank,
  input logic        ppu_vram,
  input logic [5:0]  prg_bank,
  input logic [7:0]  snd_addr,
  input logic        snd_strobe,
  input logic [1:0]  mirror_mode
);
  localparam logic [5:0] LAST_BANK = 6'(PRG_BANKS - 1);

  // R7
  snd_strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr == 16'hF800) |=> snd_strobe);

  // R7
  snd_strobe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_wr && cpu_addr == 16'hF800) |=> !snd_strobe);

  // R7
  snd_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_wr && cpu_addr == 16'hF800) |=> $stable(snd_addr));

  // R6
  prg_last_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:13] == 3'b111) |-> (prg_bank == LAST_BANK));

  // R3
  pat_ram_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ppu_addr[13] && ppu_vram) |-> (ppu_bank[7:5] == 3'b000));

  // R5
  nt_ram_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ppu_addr[13] && ppu_vram) |-> (ppu_bank[7:1] == 7'b0));

  if (VARIANT < 2) begin : g_fixed
    // R11
    mirror_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mirror_mode == 2'd0);
  end else if (VARIANT == 2) begin : g_v2
    // R9
    mirror_v2_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && cpu_addr[15:11] == 5'b11100) |=>
        (mirror_mode == ($past(cpu_data[6]) ? 2'd1 : 2'd3)));
  end else begin : g_v3
    // R10
    mirror_v3_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && cpu_addr[15:11] == 5'b11100) |=>
        (mirror_mode == ($past(cpu_data[7]) ? 2'd2 : 2'd1)));
  end
endmodule

bind cart_bank_mapper cbm_checker #(.VARIANT(VARIANT), .PRG_BANKS(PRG_BANKS)) u_cbm_checker (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .cpu_wr      (cpu_wr),
  .cpu_addr    (cpu_addr),
  .cpu_data    (cpu_data),
  .ppu_addr    (ppu_addr),
  .ppu_bank    (ppu_bank),
  .ppu_vram    (ppu_vram),
  .prg_bank    (prg_bank),
  .snd_addr    (snd_addr),
  .snd_strobe  (snd_strobe),
  .mirror_mode (mirror_mode)
);

// File: tb/test_cart_bank_mapper.sv
`timescale 1ns/1ps
module test_cart_bank_mapper;
  localparam int NV     = 4;
  localparam int BANKS  = 32;
  localparam int WD_MAX = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0;
  logic [13:0] ppu_addr = '0;

  logic [7:0]  o_bank [NV];
  logic        o_vram [NV];
  logic [5:0]  o_prg  [NV];
  logic [7:0]  o_snd  [NV];
  logic        o_stb  [NV];
  logic [1:0]  o_mir  [NV];

  always #2.5 clk = ~clk;

  for (genvar v = 0; v < NV; v++) begin : g_var
    cart_bank_mapper #(.VARIANT(v), .PRG_BANKS(BANKS)) i_cart_bank_mapper (
      .clk (clk), .rst_n (rst_n), .cpu_wr (cpu_wr), .cpu_addr (cpu_addr),
      .cpu_data (cpu_data), .ppu_addr (ppu_addr), .ppu_bank (o_bank[v]),
      .ppu_vram (o_vram[v]), .prg_bank (o_prg[v]), .snd_addr (o_snd[v]),
      .snd_strobe (o_stb[v]), .mirror_mode (o_mir[v])
    );
  end

  // behavioural reference: slots 0..7 pattern, 8..11 nametable
  int m_vram [NV][12];
  int m_bank [NV][12];
  int m_prg  [NV][3];
  int m_dlo  [NV];
  int m_dhi  [NV];
  int m_snd  [NV];
  int m_stb  [NV];
  int m_mir  [NV];

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int v = 0; v < NV; v++) begin
        for (int s = 0; s < 12; s++) begin m_vram[v][s] = 0; m_bank[v][s] = 0; end
        for (int p = 0; p < 3; p++) m_prg[v][p] = 0;
        m_dlo[v] = 0; m_dhi[v] = 0; m_snd[v] = 0; m_stb[v] = 0; m_mir[v] = 0;
      end
    end else begin
      for (int v = 0; v < NV; v++) begin
        int a, d, w;
        a = int'(cpu_addr); d = int'(cpu_data); w = (a >> 11) & 15;
        m_stb[v] = (cpu_wr && a == 'hF800) ? 1 : 0;
        if (cpu_wr && a >= 'h8000) begin
          if (w < 8) begin
            if (d < 'hE0 || ((w < 4) ? m_dlo[v] : m_dhi[v]) != 0) begin
              m_vram[v][w] = 0; m_bank[v][w] = d;
            end else begin
              m_vram[v][w] = 1; m_bank[v][w] = d & 31;
            end
          end else if (w < 12) begin
            if (v == 0) begin
              if (d <= 'hDF) begin m_vram[v][w] = 0; m_bank[v][w] = d; end
              else begin m_vram[v][w] = 1; m_bank[v][w] = d & 1; end
            end
          end else if (w == 12) begin
            m_prg[v][0] = d & 63;
            if (v == 2) m_mir[v] = ((d & 'h40) != 0) ? 1 : 3;
            if (v == 3) m_mir[v] = ((d & 'h80) != 0) ? 2 : 1;
            if (v >= 2) begin
              for (int j = 0; j < 4; j++) begin
                m_vram[v][8+j] = 1;
                m_bank[v][8+j] = (m_mir[v] == 1) ? (j & 1) : (m_mir[v] == 2) ? (j >> 1) : 0;
              end
            end
          end else if (w == 13) begin
            m_prg[v][1] = d & 63;
            m_dlo[v] = (d >> 6) & 1;
            m_dhi[v] = (d >> 7) & 1;
          end else if (w == 14) begin
            m_prg[v][2] = d & 63;
          end else if (a == 'hF800) begin
            m_snd[v] = d;
          end
        end
      end
    end
  end

  // per-clock comparison of registered outputs
  always @(negedge clk) begin
    cycles++;
    for (int v = 0; v < NV; v++) begin
      check("R7", $sformatf("v%0d snd_addr", v), int'(o_snd[v]), m_snd[v]);
      check("R7", $sformatf("v%0d snd_strobe", v), int'(o_stb[v]), m_stb[v]);
      check((v < 2) ? "R11" : (v == 2) ? "R9" : "R10",
            $sformatf("v%0d mirror_mode", v), int'(o_mir[v]), m_mir[v]);
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    #0.5;
    cpu_wr = 1'b1; cpu_addr = 16'(a); cpu_data = 8'(d);
    @(negedge clk);
    #0.5;
    cpu_wr = 1'b0;
  endtask

  task automatic lookup_all(input string tag);
    for (int s = 0; s < 12; s++) begin
      @(negedge clk);
      #0.5;
      ppu_addr = (s < 8) ? 14'(s * 1024 + 'h155) : 14'('h2000 + (s - 8) * 1024 + ((s & 1) * 'h1000) + 'h2A);
      #1;
      for (int v = 0; v < NV; v++) begin
        string t;
        t = (s < 8) ? tag : (v == 0) ? "R5" : (v == 1) ? "R8" : (v == 2) ? "R9" : "R10";
        check(t, $sformatf("v%0d slot%0d bank", v, s), int'(o_bank[v]), m_bank[v][s]);
        check(t, $sformatf("v%0d slot%0d vram", v, s), int'(o_vram[v]), m_vram[v][s]);
      end
    end
    for (int w = 0; w < 4; w++) begin
      @(negedge clk);
      #0.5;
      cpu_addr = 16'('h8000 + w * 'h2000 + 'h123);
      #1;
      for (int v = 0; v < NV; v++)
        check("R6", $sformatf("v%0d prg win%0d", v, w), int'(o_prg[v]),
              (w == 3) ? BANKS - 1 : m_prg[v][w]);
    end
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    lookup_all("R1");
    // R2: below-window write ignored, pattern slots in order
    wr('h6000, 'h55);
    wr('h7FFF, 'hE7);
    for (int k = 0; k < 8; k++) wr('h8000 + k * 'h800 + k, 'h10 + k * 3);
    lookup_all("R2");
    // R3: thresholds with flags clear
    wr('h8000, 'hDF); wr('h8800, 'hE0); wr('hB000, 'hFF); wr('hB800, 'hE9);
    lookup_all("R3");
    // R4: set low disable, write both halves, then flip flags
    wr('hE800, 'h47);
    wr('h8000, 'hE3); wr('hA000, 'hF7);
    lookup_all("R4");
    wr('hE800, 'h80);
    lookup_all("R4");
    wr('h8800, 'hE2); wr('hA800, 'hE1);
    lookup_all("R4");
    // R5 / R8: nametable thresholds
    wr('hC000, 'hDF); wr('hC800, 'hE0); wr('hD000, 'hE1); wr('hD800, 'h42);
    lookup_all("R5");
    // R6: program banks
    wr('hE000, 'hFF); wr('hE800, 'h2A); wr('hF000, 'h81);
    lookup_all("R6");
    // R7: sound decode
    wr('hF801, 'h33); wr('hFFFF, 'h44); wr('hF800, 'hA5);
    wr('hF800, 'h5A); wr('hF800, 'h00);
    repeat (3) @(negedge clk);
    // R9 / R10: mirroring both ways
    wr('hE000, 'h40); lookup_all("R9");
    wr('hE000, 'h80); lookup_all("R10");
    wr('hE000, 'hC0); lookup_all("R9");
    wr('hE000, 'h00); lookup_all("R10");
    wr('hC800, 'hE1); lookup_all("R8");
    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    wait (cycles > WD_MAX);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, WD_MAX);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule